// File: doc/BRIEF.md
# Pixel Digitizer Serial Control and Readout Port

This block is the digital front of a line-scan pixel digitizer. One serial data line serves two jobs, chosen by a direction input. With the direction input low, a host clocks in 8-bit control words that set a 2-bit analog source select and a 6-bit gain code. With the direction input high, the block shifts out 8-bit conversion results. A result is captured on each falling edge of the pixel strobe, and it reaches the data line two pixel periods later. The converter itself is modelled by a parallel result input.

All pin inputs (serial clock, load strobe, pixel strobe, direction, serial data in) are first brought into the system clock domain through a synchronizer chain, then edge-detected. After that every state change happens on the system clock. The data line is split into a data-out and an output-enable, so that a pad cell can build the tri-state driver. Two state machines do the work. The control receiver has the states CF_IDLE, CF_SHIFT and CF_FULL. Its transitions are: first bit (IDLE→SHIFT), eighth bit (SHIFT→FULL), load rise (SHIFT/FULL→IDLE) and direction change (any→IDLE). The readout machine has the states RO_EMPTY, RO_SHIFT and RO_SPENT. Its transitions are: pixel strobe fall (any→SHIFT), seventh readout step (SHIFT→SPENT) and reset (→EMPTY).

Top module: `pixel_serial_port`

## Requirements
- R1: After a synchronous reset the source select is 0 (main sensor path), the gain code is 0, data_out is 0, and data_oe is 0 while mode_pin is low.
- R2: data_oe is 1 whenever mode_pin is high and 0 whenever it is low. This is the result-readout direction versus the control-write direction.
- R3: In control direction each serial clock rise shifts in one bit, first bit into word bit 7. Word bits 7:6 are the address (01 = source select, 10 = gain, 00 and 11 = no operation) and bits 5:0 are the payload.
- R4: A load rise after at least eight bits, with address 10, copies the 6-bit payload into gain_code (range 0 to 63).
- R5: With address 01, payload bits 1:0 set mux_sel (00 sensor path, 01 auxiliary 1, 10 auxiliary 2). Payload value 11 leaves mux_sel unchanged, and payload bits 5:2 are ignored.
- R6: A complete word with address 00 or 11 changes neither mux_sel nor gain_code.
- R7: A load rise with fewer than eight bits received is ignored and clears the bit count, so bits received before it never count toward a later word.
- R8: Any change of mode_pin clears the bit count.
- R9: When more than eight bits arrive before the load rise, the last eight received form the word.
- R10: A load rise while mode_pin is high changes no control register.
- R11: A result_in value captured at pixel strobe fall k has its bit 7 on data_out from strobe fall k+2 on, with no serial clock edge needed.
- R12: In readout direction each serial clock rise moves the next lower result bit (6 down to 0) onto data_out.
- R13: Serial clock rises in control direction leave the pending readout word untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_pin | input | 1 | Serial clock from host (asynchronous) |
| load_pin | input | 1 | Control word commit strobe (asynchronous) |
| pix_strobe | input | 1 | Pixel sample strobe; falling edge captures a result |
| mode_pin | input | 1 | Direction: 0 control write, 1 result readout |
| data_in | input | 1 | Serial data from the pad input buffer |
| data_out | output | 1 | Serial data to the pad driver |
| data_oe | output | 1 | Pad driver enable; 0 leaves the line high impedance |
| result_in | input | WORD_W | Conversion result from the converter |
| mux_sel | output | 2 | Analog source select register |
| gain_code | output | WORD_W-2 | Gain register, gain = -(2 + code/8) |

## Verification
The bench builds the block with its defaults: an 8-bit word and a two-stage synchronizer. With these values the full 0 to 63 gain range is reached, including both end codes, and all four address codes are exercised. The three-stage result pipeline can be walked with distinct words, so an off-by-one pixel of latency shows on the first bit. Because the synchronizer is two stages deep, the bench holds each pin level for six clocks, which lets each host edge be seen exactly once.

// File: rtl/pixport_pkg.sv
package pixport_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [1:0] {
        CF_IDLE,
        CF_SHIFT,
        CF_FULL
    } cfg_state_t;

    typedef enum logic [1:0] {
        RO_EMPTY,
        RO_SHIFT,
        RO_SPENT
    } ro_state_t;

    typedef enum logic [1:0] {
        ADDR_NOP_LO = 2'b00,
        ADDR_SRC    = 2'b01,
        ADDR_GAIN   = 2'b10,
        ADDR_NOP_HI = 2'b11
    } addr_t;

    typedef enum logic [1:0] {
        SRC_SENSOR = 2'b00,
        SRC_AUX1   = 2'b01,
        SRC_AUX2   = 2'b10
    } src_t;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int STAGES = 2,
    parameter int N      = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] level,
    output logic [N-1:0] prev
);

    logic [STAGES-1:0][N-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
            prev <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];

endmodule

// File: rtl/cfg_receiver.sv
module cfg_receiver
    import pixport_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     mode_hi,
    input  logic                     mode_flip,
    input  logic                     sclk_rise,
    input  logic                     load_rise,
    input  logic                     din,
    output logic [1:0]               mux_sel,
    output logic [WORD_W-ADDR_W-1:0] gain_code
);

    localparam int PAY_W = WORD_W - ADDR_W;
    localparam int CNT_W = $clog2(WORD_W + 1);

    cfg_state_t       st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [WORD_W-1:0] sh;
    logic             shift_en;
    logic             take;
    logic             commit;
    logic [PAY_W-1:0] payload;
    addr_t            addr;

    assign shift_en = sclk_rise && !mode_hi && !mode_flip;
    assign take     = load_rise && !mode_hi && !mode_flip;
    assign commit   = take && (st == CF_FULL);
    assign payload  = sh[PAY_W-1:0];
    assign addr     = addr_t'(sh[WORD_W-1 -: ADDR_W]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= CF_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        if (mode_flip) begin
            st_nx  = CF_IDLE;
            cnt_nx = '0;
        end else begin
            unique case (st)
                CF_IDLE: begin
                    if (shift_en) begin
                        st_nx  = CF_SHIFT;
                        cnt_nx = CNT_W'(1);
                    end
                end
                CF_SHIFT: begin
                    if (take) begin
                        st_nx  = CF_IDLE;
                        cnt_nx = '0;
                    end else if (shift_en) begin
                        cnt_nx = cnt + 1'b1;
                        if (cnt == CNT_W'(WORD_W - 1)) begin
                            st_nx = CF_FULL;
                        end
                    end
                end
                CF_FULL: begin
                    if (take) begin
                        st_nx  = CF_IDLE;
                        cnt_nx = '0;
                    end
                end
                default: begin
                    st_nx  = CF_IDLE;
                    cnt_nx = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh        <= '0;
            mux_sel   <= 2'(SRC_SENSOR);
            gain_code <= '0;
        end else begin
            if (shift_en) begin
                sh <= {sh[WORD_W-2:0], din};
            end
            if (commit) begin
                unique case (addr)
                    ADDR_SRC: begin
                        if (payload[1:0] != 2'b11) begin
                            mux_sel <= payload[1:0];
                        end
                    end
                    ADDR_GAIN:   gain_code <= payload;
                    ADDR_NOP_LO: ;
                    ADDR_NOP_HI: ;
                    default:     ;
                endcase
            end
        end
    end

    // R5
    mux_legal_chk: assert property (@(posedge clk) disable iff (rst)
        mux_sel != 2'b11);

    // R7
    short_load_chk: assert property (@(posedge clk) disable iff (rst)
        (load_rise && st != CF_FULL) |=> ($stable(gain_code) && $stable(mux_sel)));

    // R8
    flip_clear_chk: assert property (@(posedge clk) disable iff (rst)
        mode_flip |=> (cnt == '0 && st == CF_IDLE));

    // R10
    load_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (load_rise && mode_hi) |=> ($stable(gain_code) && $stable(mux_sel)));

    // R4
    gain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!commit && !$past(rst)) |=> $stable(gain_code));

endmodule

// File: rtl/result_pipe.sv
module result_pipe
    import pixport_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_hi,
    input  logic              sclk_rise,
    input  logic              pix_fall,
    input  logic [WORD_W-1:0] result_in,
    output logic              data_bit
);

    localparam int CNT_W = $clog2(WORD_W);

    ro_state_t         st, st_nx;
    logic [CNT_W-1:0]  left, left_nx;
    logic [WORD_W-1:0] conv_q, store_q, out_sh;
    logic              step;

    assign step = sclk_rise && mode_hi && !pix_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= RO_EMPTY;
            left <= '0;
        end else begin
            st   <= st_nx;
            left <= left_nx;
        end
    end

    always_comb begin
        st_nx   = st;
        left_nx = left;
        if (pix_fall) begin
            st_nx   = RO_SHIFT;
            left_nx = CNT_W'(WORD_W - 1);
        end else begin
            unique case (st)
                RO_EMPTY: ;
                RO_SHIFT: begin
                    if (step) begin
                        left_nx = left - 1'b1;
                        if (left == CNT_W'(1)) begin
                            st_nx = RO_SPENT;
                        end
                    end
                end
                RO_SPENT: ;
                default: st_nx = RO_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_q  <= '0;
            store_q <= '0;
            out_sh  <= '0;
        end else if (pix_fall) begin
            conv_q  <= result_in;
            store_q <= conv_q;
            out_sh  <= store_q;
        end else if (step) begin
            out_sh <= {out_sh[WORD_W-2:0], 1'b0};
        end
    end

    assign data_bit = out_sh[WORD_W-1];

    // R11
    strobe_load_chk: assert property (@(posedge clk) disable iff (rst)
        pix_fall |=> (st == RO_SHIFT && left == CNT_W'(WORD_W - 1)));

    // R12
    step_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (step && st == RO_SHIFT) |=> data_bit == $past(out_sh[WORD_W-2]));

    // R13
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!pix_fall && !(sclk_rise && mode_hi)) |=> $stable(out_sh));

endmodule

// File: rtl/pixel_serial_port.sv
module pixel_serial_port
    import pixport_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sclk_pin,
    input  logic                     load_pin,
    input  logic                     pix_strobe,
    input  logic                     mode_pin,
    input  logic                     data_in,
    output logic                     data_out,
    output logic                     data_oe,
    input  logic [WORD_W-1:0]        result_in,
    output logic [1:0]               mux_sel,
    output logic [WORD_W-ADDR_W-1:0] gain_code
);

    localparam int IX_SCLK = 0;
    localparam int IX_LOAD = 1;
    localparam int IX_PIX  = 2;
    localparam int IX_MODE = 3;
    localparam int IX_DIN  = 4;
    localparam int N_PINS  = 5;

    logic [N_PINS-1:0] pins_raw, lvl, prv;
    logic sclk_rise, load_rise, pix_fall, mode_flip;
    logic unused_prev;

    assign pins_raw = {data_in, mode_pin, pix_strobe, load_pin, sclk_pin};

    pin_sync #(
        .STAGES (SYNC_STAGES),
        .N      (N_PINS)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pins_raw),
        .level    (lvl),
        .prev     (prv)
    );

    assign sclk_rise = lvl[IX_SCLK] && !prv[IX_SCLK];
    assign load_rise = lvl[IX_LOAD] && !prv[IX_LOAD];
    assign pix_fall  = !lvl[IX_PIX] && prv[IX_PIX];
    assign mode_flip = lvl[IX_MODE] != prv[IX_MODE];
    assign unused_prev = prv[IX_DIN];

    cfg_receiver #(
        .WORD_W (WORD_W)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .mode_hi   (lvl[IX_MODE]),
        .mode_flip (mode_flip),
        .sclk_rise (sclk_rise),
        .load_rise (load_rise),
        .din       (lvl[IX_DIN]),
        .mux_sel   (mux_sel),
        .gain_code (gain_code)
    );

    result_pipe #(
        .WORD_W (WORD_W)
    ) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .mode_hi   (lvl[IX_MODE]),
        .sclk_rise (sclk_rise),
        .pix_fall  (pix_fall),
        .result_in (result_in),
        .data_bit  (data_out)
    );

    assign data_oe = lvl[IX_MODE];

endmodule

// File: tb/pixel_serial_port_test.sv
module pixel_serial_port_test;

    localparam int CLK_T  = 10;
    localparam int WORD_W = 8;
    localparam int HOLD   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk_pin = 1'b0;
    logic load_pin = 1'b0;
    logic pix_strobe = 1'b0;
    logic mode_pin = 1'b0;
    logic data_in = 1'b0;
    logic [WORD_W-1:0] result_in = '0;
    logic data_out, data_oe;
    logic [1:0] mux_sel;
    logic [WORD_W-3:0] gain_code;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_T/2) clk = ~clk;

    pixel_serial_port #(.WORD_W(WORD_W), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .sclk_pin(sclk_pin), .load_pin(load_pin),
        .pix_strobe(pix_strobe), .mode_pin(mode_pin), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .result_in(result_in),
        .mux_sel(mux_sel), .gain_code(gain_code)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic sclk_pulse();
        sclk_pin = 1'b1; settle();
        sclk_pin = 1'b0; settle();
    endtask

    task automatic load_pulse();
        load_pin = 1'b1; settle();
        load_pin = 1'b0; settle();
    endtask

    task automatic set_mode(input logic m);
        mode_pin = m; settle();
    endtask

    // shift bits word[hi] down to word[hi-n+1]
    task automatic send_bits(input logic [WORD_W-1:0] w, input int hi, input int n);
        for (int i = hi; i > hi - n; i--) begin
            data_in = w[i];
            sclk_pulse();
        end
    endtask

    task automatic write_word(input logic [WORD_W-1:0] w);
        send_bits(w, WORD_W-1, WORD_W);
        load_pulse();
    endtask

    task automatic pix_pulse(input logic [WORD_W-1:0] v);
        result_in = v;
        pix_strobe = 1'b1; settle();
        pix_strobe = 1'b0; settle();
    endtask

    task automatic read_word(input string req, input logic [WORD_W-1:0] exp);
        for (int i = WORD_W-1; i >= 0; i--) begin
            check(req, int'(data_out), int'(exp[i]));
            if (i > 0) sclk_pulse();
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle();
        check("R1 mux", int'(mux_sel), 0);
        check("R1 gain", int'(gain_code), 0);
        check("R1 oe", int'(data_oe), 0);
        check("R1 dout", int'(data_out), 0);
    endtask

    task automatic t_gain();
        write_word(8'hAD);
        check("R3 R4 gain 2D", int'(gain_code), 'h2D);
        check("R4 mux untouched", int'(mux_sel), 0);
        write_word(8'hBF);
        check("R4 gain max", int'(gain_code), 63);
        write_word(8'h80);
        check("R4 gain min", int'(gain_code), 0);
    endtask

    task automatic t_mux();
        write_word(8'h41);
        check("R5 aux1", int'(mux_sel), 1);
        write_word(8'h42);
        check("R5 aux2", int'(mux_sel), 2);
        write_word(8'h43);
        check("R5 code 11 ignored", int'(mux_sel), 2);
        write_word(8'h7C);
        check("R5 upper payload ignored", int'(mux_sel), 0);
        check("R5 gain untouched", int'(gain_code), 0);
    endtask

    task automatic t_nop();
        write_word(8'h86);
        write_word(8'h41);
        write_word(8'h15);
        check("R6 nop00 gain", int'(gain_code), 6);
        check("R6 nop00 mux", int'(mux_sel), 1);
        write_word(8'hD5);
        check("R6 nop11 gain", int'(gain_code), 6);
        check("R6 nop11 mux", int'(mux_sel), 1);
    endtask

    task automatic t_short();
        send_bits(8'h9F, 7, 5);
        load_pulse();
        check("R7 short load", int'(gain_code), 6);
        send_bits(8'h9F, 2, 3);
        load_pulse();
        check("R7 count cleared", int'(gain_code), 6);
        write_word(8'h85);
        check("R7 next word ok", int'(gain_code), 5);
    endtask

    task automatic t_modeflip();
        send_bits(8'hA7, 7, 3);
        set_mode(1'b1);
        set_mode(1'b0);
        send_bits(8'hA7, 4, 5);
        load_pulse();
        check("R8 flip clears count", int'(gain_code), 5);
    endtask

    task automatic t_long();
        data_in = 1'b1; sclk_pulse();
        data_in = 1'b1; sclk_pulse();
        write_word(8'h8A);
        check("R9 last eight bits", int'(gain_code), 'h0A);
    endtask

    task automatic t_load_hi();
        send_bits(8'h9C, 7, 8);
        set_mode(1'b1);
        check("R2 oe high", int'(data_oe), 1);
        load_pulse();
        check("R10 load in readout", int'(gain_code), 'h0A);
        set_mode(1'b0);
        check("R2 oe low", int'(data_oe), 0);
    endtask

    task automatic t_readout();
        set_mode(1'b1);
        pix_pulse(8'hA5);
        pix_pulse(8'h3C);
        check("R11 not yet", int'(data_out), 0);
        pix_pulse(8'hF0);
        read_word("R11 R12 word A5", 8'hA5);
        pix_pulse(8'h00);
        read_word("R12 word 3C", 8'h3C);
        check("R10 cfg after readout", int'(gain_code), 'h0A);
    endtask

    task automatic t_hold();
        pix_pulse(8'h11);
        set_mode(1'b0);
        data_in = 1'b0;
        repeat (3) sclk_pulse();
        set_mode(1'b1);
        read_word("R13 word F0 kept", 8'hF0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_gain();
        t_mux();
        t_nop();
        t_short();
        t_modeflip();
        t_long();
        t_load_hi();
        t_readout();
        t_hold();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule